// File: doc/BRIEF.md
# Edge-Tracking Oversampling Bit Sampler

This block recovers bits from a serial line whose clock is not sent along with the data. It runs on a local clock at OSR times the nominal bit rate. OSR is fixed at build time, defaults to 4, and must be at least 3. The line first passes through a synchroniser. Every change of level is then treated as a bit boundary, and the internal phase counter restarts there. The block never estimates the remote frequency. Instead, it takes its sample a fixed half bit after the most recent boundary, so each sample lands near the middle of the bit.

The block produces a stream of recovered bits, one per sample point. Each bit is marked by a one-clock valid strobe. The line cannot be paused, so this stream has no ready input and no back-pressure: a consumer must accept each bit in the cycle it is strobed. There is also a separate plain flag. It pulses when a boundary arrives so far from its expected position that the direction of the slip cannot be told.

Top module: `edge_track_sampler`

## Requirements
- R1: While rst_n is low, bit_out, bit_valid and phase_err are 0. After release they stay 0 until the first sample point. Line history from before release counts as level 0.
- R2: line_in passes through a SYNC_STAGES-deep synchroniser (default 2). A level change captured at rising clock k is an edge, and it restarts the phase. The next bit_valid pulse then follows rising edge k+2+OSR/2, unless a further edge comes first.
- R3: Without edges, sample points keep coming OSR clocks apart with no limit on how long the line stays constant. Number the first rising edge after reset release as 0: the first strobe then follows rising edge OSR/2.
- R4: bit_valid is high for exactly one clock per sample. bit_out changes only in a cycle where bit_valid is high, and it holds its value otherwise.
- R5: When a strobe follows rising edge j, bit_out equals the level of line_in captured at rising edge j-2.
- R6: An edge within plus or minus W samples of its expected position (W = (OSR-1)/2) realigns the phase without raising phase_err. For OSR=4, line bits lasting 3, 4 or 5 clocks give strobes 3, 4 or 5 clocks apart.
- R7: This requirement applies to even OSR only. An edge that lands exactly OSR/2 samples from its expected position (on the due sample point) raises phase_err for one clock after rising edge k+2. The sample due in that cycle is dropped, and the edge still realigns the phase. With odd OSR, phase_err stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, OSR times the nominal bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous serial line |
| bit_out | output | 1 | Most recently recovered bit |
| bit_valid | output | 1 | One-clock strobe marking a new bit_out |
| phase_err | output | 1 | One-clock pulse for an edge with ambiguous direction |

## Verification
Take a level change on line_in that is captured at rising clock k. The synchroniser and the edge register put its phase_err pulse one clock after rising edge k+2. The realigned strobe comes OSR/2 clocks after that. Any strobe's bit_out reflects the line exactly two rising edges earlier. The bench replays the captured line history in a behavioural model that applies these offsets. It then compares all three outputs at every falling edge, so each check lands in the cycle where the registered result is due. The stimulus covers on-time bits, bits one clock short and one clock long, the ambiguous half-bit offset, long constant stretches and irregular widths.

// File: rtl/ets_pkg.sv
package ets_pkg;

  // Per-cycle decision handed from the phase tracker to the output stage.
  typedef struct packed {
    logic take;   // sample point reached this cycle
    logic level;  // synchronised line level to capture
    logic slip;   // edge whose direction cannot be resolved
  } ets_evt_t;

  // Half-width of the correction window in samples.
  function automatic int win_of(input int osr);
    return (osr - 1) / 2;
  endfunction

endpackage

// File: rtl/ets_sync.sv
module ets_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ets_phase.sv
module ets_phase
  import ets_pkg::*;
#(
  parameter  int OSR = 4,
  localparam int PW  = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  output ets_evt_t      evt,
  output logic          edge_o,
  output logic [PW-1:0] phase_o
);

  localparam logic [PW-1:0] LAST  = PW'(OSR - 1);
  localparam logic [PW-1:0] HALFP = PW'(OSR / 2);
  localparam logic [PW-1:0] ONE   = PW'(1);

  logic          prev_q;
  logic [PW-1:0] ph_q, ph_d;
  logic          edge_w;
  logic          slip_w;

  assign edge_w = line_s ^ prev_q;

  // Phase 0 is the edge cycle itself, so the count restarts at 1.
  always_comb begin
    if (edge_w)            ph_d = ONE;
    else if (ph_q == LAST) ph_d = '0;
    else                   ph_d = ph_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      prev_q <= line_s;
      ph_q   <= ph_d;
    end
  end

  // Only an even ratio has a sample offset that is equally early and late.
  generate
    if (OSR % 2 == 0) begin : g_even
      assign slip_w = edge_w && (ph_q == HALFP);
    end else begin : g_odd
      assign slip_w = 1'b0;
    end
  endgenerate

  assign evt     = '{take: !edge_w && (ph_q == HALFP), level: line_s, slip: slip_w};
  assign edge_o  = edge_w;
  assign phase_o = ph_q;

  // R2: every edge restarts the bit phase
  assert_realign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (ph_q == ONE));

  // R3: with no edge the counter wraps and keeps running
  assert_freewheel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_w && ph_q == LAST) |=> (ph_q == '0));

endmodule

// File: rtl/ets_out.sv
module ets_out
  import ets_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ets_evt_t evt,
  output logic     bit_out,
  output logic     bit_valid,
  output logic     phase_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
      phase_err <= 1'b0;
    end else begin
      bit_valid <= evt.take;
      phase_err <= evt.slip;
      if (evt.take) bit_out <= evt.level;
    end
  end

  // R4: strobe lasts a single clock
  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R4: recovered bit is stable between strobes
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> (bit_out == $past(bit_out)));

endmodule

// File: rtl/edge_track_sampler.sv
module edge_track_sampler
  import ets_pkg::*;
#(
  parameter int OSR         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_out,
  output logic bit_valid,
  output logic phase_err
);

  localparam int HALF = OSR / 2;
  localparam int WIN  = win_of(OSR);
  localparam int PW   = $clog2(OSR);
  localparam bit EVEN = (OSR % 2 == 0);

  generate
    if (OSR < 3 || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("edge_track_sampler: OSR must be >= 3 and SYNC_STAGES >= 2");
    end
  endgenerate

  logic          line_s;
  ets_evt_t      evt;
  logic          edge_w;
  logic [PW-1:0] ph_w;

  ets_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_in),
    .dout (line_s)
  );

  ets_phase #(.OSR(OSR)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_s (line_s),
    .evt    (evt),
    .edge_o (edge_w),
    .phase_o(ph_w)
  );

  ets_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .bit_out  (bit_out),
    .bit_valid(bit_valid),
    .phase_err(phase_err)
  );

  // R5: mid-bit sample point yields a strobe carrying the synchronised level
  assert_mid_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_w && ph_w == PW'(HALF)) |=> (bit_valid && bit_out == $past(line_s)));

  // R7: ambiguous edge flags and drops that sample
  assert_slip_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (EVEN && edge_w && ph_w == PW'(HALF)) |=> (phase_err && !bit_valid));

  // R6: edges inside the correction window are absorbed silently
  assert_window_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && (int'(ph_w) <= WIN || int'(ph_w) >= OSR - WIN)) |=> !phase_err);

endmodule

// File: tb/edge_track_sampler_tb.sv
module edge_track_sampler_tb;

  localparam int CLK_NS = 10;
  localparam int OSR    = 4;
  localparam int HALF   = OSR / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic bit_out, bit_valid, phase_err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit checking = 0;
  string cur_req = "R1";

  edge_track_sampler #(.OSR(OSR)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .bit_out  (bit_out),
    .bit_valid(bit_valid),
    .phase_err(phase_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of captured line levels, last edge index.
  bit hist[$];
  int p_idx = 0;
  int e_last = -2;
  bit exp_valid = 0, exp_err = 0, exp_bit = 0;

  always @(posedge clk) begin
    int i, ph;
    bit cur, prv, edg;
    if (!rst_n) begin
      exp_valid = 0; exp_err = 0; exp_bit = 0;
      p_idx = 0; e_last = -2;
      hist.delete();
    end else begin
      hist.push_back(line_in);
      i   = p_idx - 2;
      cur = (i >= 0) ? hist[i] : 1'b0;
      prv = (i >= 1) ? hist[i-1] : 1'b0;
      edg = (cur != prv);
      ph  = (((i - e_last) % OSR) + OSR) % OSR;
      exp_valid = !edg && (ph == HALF);
      exp_err   = edg && (OSR % 2 == 0) && (ph == OSR / 2);
      if (exp_valid) exp_bit = cur;
      if (edg) e_last = i;
      p_idx++;
    end
  end

  bit prev_valid = 0, prev_bit = 0;

  always @(negedge clk) begin
    if (checking) begin
      chk(bit_valid === exp_valid, cur_req, "bit_valid", int'(bit_valid), int'(exp_valid));
      chk(phase_err === exp_err, "R7", "phase_err", int'(phase_err), int'(exp_err));
      chk(bit_out === exp_bit, "R5", "bit_out", int'(bit_out), int'(exp_bit));
      chk(!(bit_valid && prev_valid), "R4", "strobe width", int'(bit_valid), 0);
      chk(bit_valid || (bit_out === prev_bit), "R4", "hold between strobes",
          int'(bit_out), int'(prev_bit));
      prev_valid = bit_valid;
      prev_bit   = bit_out;
    end
  end

  // Drive a level, starting at a falling edge, for a number of clocks.
  task automatic hold(input bit lvl, input int clocks);
    line_in = lvl;
    repeat (clocks) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    lfsr = 8'h5B;
    @(posedge clk);
    @(negedge clk);
    checking = 1;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R3";
    hold(1'b0, 24);
    cur_req = "R2";
    hold(1, 4); hold(0, 4); hold(1, 8); hold(0, 12); hold(1, 4); hold(0, 4);
    cur_req = "R6";
    for (int k = 0; k < 12; k++) begin
      hold(~line_in, (k % 3 == 0) ? 5 : ((k % 3 == 1) ? 3 : 4));
    end
    cur_req = "R3";
    hold(1, 4);
    hold(0, 28);
    cur_req = "R7";
    hold(1, 6); hold(0, 6); hold(1, 4); hold(0, 6); hold(1, 4);
    cur_req = "R6";
    for (int k = 0; k < 60; k++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
      hold(~line_in, (lfsr % 7) + 1);
    end
    hold(0, 20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule